// File: doc/BRIEF.md
# Runt Frame Padder and Framer

This block sits between a low-rate port, where Ethernet frames may arrive shorter than the Ethernet minimum, and a standards-compliant media-independent interface. It accepts a byte stream with a last-byte marker. Each frame holds a destination address, a source address, an EtherType, a payload of zero or more bytes, and a 4-byte FCS. The block stores the whole frame. Frames that exceed the maximum legal size are discarded.

A frame that is kept goes out as one unbroken byte burst. The burst starts with a preamble and a start-of-frame delimiter. Next come the frame's header and payload, with the incoming FCS removed. If that content is shorter than 60 bytes, zeros are appended until it is 60 bytes long. A freshly computed CRC-32 follows. After each burst the output stays idle for an enforced gap before the next frame may begin.

While a frame is being emitted, and during the gap that follows, the input is held off through its ready signal.

Top module: `runt_pad_framer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_en` is 0 and `drop_count` is 0.
- R2: Every emitted frame begins with seven bytes of 0x55, followed by one byte of 0xD5.
- R3: For a frame of fewer than 64 bytes including its FCS, the output carries the input bytes without their last four. Zero bytes follow until exactly 60 content bytes have been sent.
- R4: For a frame of 64 bytes or more including its FCS, the output carries every input byte except the last four, unchanged and in order, and adds no padding.
- R5: After the content bytes come four FCS bytes, least significant byte first. The FCS is a CRC-32 over the content bytes, including any padding. It uses the reflected polynomial 0xEDB88320, an initial value of 0xFFFFFFFF and a final inversion.
- R6: Between the last FCS byte of one frame and the first preamble byte of the next, `out_en` is low for at least 12 consecutive cycles.
- R7: A frame of more than 1518 bytes including its FCS produces no output and raises `drop_count` by exactly one. The next frame is handled normally.
- R8: `in_ready` is low in every cycle in which `out_en` is high. `out_en` stays high without a break from the first preamble byte to the last FCS byte.
- R9: A frame of exactly 1518 bytes is forwarded in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input byte is offered |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | The offered byte is the last byte of its frame |
| in_ready | output | 1 | The block takes the offered byte at this edge |
| out_en | output | 1 | `out_data` holds a frame byte |
| out_data | output | 8 | Output byte toward the MAC interface |
| drop_count | output | 16 | Number of oversized frames discarded, wrapping |

## Verification
Two functions fall in the same cycles, and each is checked.

- **Padding and CRC.** Zero padding and CRC accumulation happen together: every pad byte is emitted and folded into the running CRC in one cycle. The runt cases drive this, with payloads of 0, 1 and 45 bytes. Each input FCS is deliberately wrong, and the bench compares the FCS on the output against its own CRC of the padded content.
- **Gap and next frame.** The end of the inter-frame gap meets the arrival of a queued frame. The bench presents a second frame immediately after the first. It then checks that both bursts come out intact and that the shortest idle run between them is at least 12 cycles.

// File: rtl/runt_pad_pkg.sv
package runt_pad_pkg;

    typedef enum logic [2:0] {
        ST_RECV = 3'd0,
        ST_PRE  = 3'd1,
        ST_DATA = 3'd2,
        ST_FCS  = 3'd3,
        ST_GAP  = 3'd4
    } rpf_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] din);
        logic [31:0] c;
        c = crc ^ {24'h0, din};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rpf_crc_step.sv
module rpf_crc_step
    import runt_pad_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);
    assign crc_out = crc32_step(crc_in, byte_in);
endmodule

// File: rtl/rpf_frame_buf.sv
module rpf_frame_buf #(
    parameter int DEPTH = 1518,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam logic [AW-1:0] DEPTH_C = AW'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < DEPTH_C)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = (rd_addr < DEPTH_C) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/runt_pad_framer.sv
module runt_pad_framer
    import runt_pad_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1518,
    parameter int PRE_LEN   = 7,
    parameter int IFG_LEN   = 12,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_en,
    output logic [7:0]        out_data,
    output logic [DROP_W-1:0] drop_count
);
    localparam int FCS_LEN  = 4;
    localparam int MIN_DATA = MIN_FRAME - FCS_LEN;
    localparam int CNT_W    = $clog2(MAX_FRAME + 2);

    localparam logic [CNT_W-1:0] MAX_C      = CNT_W'(MAX_FRAME);
    localparam logic [CNT_W-1:0] MIN_DATA_C = CNT_W'(MIN_DATA);
    localparam logic [CNT_W-1:0] PRE_C      = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] FCS_LAST_C = CNT_W'(FCS_LEN - 1);
    localparam logic [CNT_W-1:0] IFG_C      = CNT_W'(IFG_LEN);
    localparam logic [CNT_W-1:0] IFG_LAST_C = CNT_W'(IFG_LEN - 1);
    localparam logic [CNT_W:0]   MAX_TOT_C  = (CNT_W+1)'(MAX_FRAME);
    localparam logic [CNT_W:0]   FCS_TOT_C  = (CNT_W+1)'(FCS_LEN);

    typedef struct packed {
        rpf_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  idx;
        logic [31:0]       crc;
        logic              out_en;
        logic [7:0]        out_data;
        logic [DROP_W-1:0] drop;
    } regs_t;

    regs_t q, d;

    logic             accept;
    logic             buf_we;
    logic [7:0]       buf_rd;
    logic [7:0]       data_byte;
    logic [31:0]      crc_nxt;
    logic [31:0]      fcs_word;
    logic [CNT_W-1:0] pad_len;
    logic [CNT_W:0]   total;

    assign in_ready  = (q.state == ST_RECV);
    assign accept    = in_valid && in_ready;
    assign buf_we    = accept && (q.cnt < MAX_C);
    assign pad_len   = (q.len < MIN_DATA_C) ? MIN_DATA_C : q.len;
    assign data_byte = (q.idx < q.len) ? buf_rd : 8'h00;
    assign total     = {1'b0, q.cnt} + (CNT_W+1)'(1);
    assign fcs_word  = ~q.crc;

    rpf_frame_buf #(
        .DEPTH (MAX_FRAME),
        .AW    (CNT_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (q.cnt),
        .wr_data (in_data),
        .rd_addr (q.idx),
        .rd_data (buf_rd)
    );

    rpf_crc_step u_crc (
        .crc_in  (q.crc),
        .byte_in (data_byte),
        .crc_out (crc_nxt)
    );

    always_comb begin
        d          = q;
        d.out_en   = 1'b0;
        d.out_data = 8'h00;
        unique case (q.state)
            ST_RECV: begin
                if (accept) begin
                    if (in_last) begin
                        d.cnt = '0;
                        if (total > MAX_TOT_C) begin
                            d.drop = q.drop + DROP_W'(1);
                        end else begin
                            d.state = ST_PRE;
                            d.idx   = '0;
                            d.len   = (total >= FCS_TOT_C) ? CNT_W'(total - FCS_TOT_C) : '0;
                        end
                    end else if (q.cnt <= MAX_C) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_PRE: begin
                d.out_en = 1'b1;
                if (q.idx == PRE_C) begin
                    d.out_data = 8'hD5;
                    d.state    = ST_DATA;
                    d.idx      = '0;
                    d.crc      = '1;
                end else begin
                    d.out_data = 8'h55;
                    d.idx      = q.idx + CNT_W'(1);
                end
            end
            ST_DATA: begin
                d.out_en   = 1'b1;
                d.out_data = data_byte;
                d.crc      = crc_nxt;
                if (q.idx == pad_len - CNT_W'(1)) begin
                    d.state = ST_FCS;
                    d.idx   = '0;
                end else begin
                    d.idx = q.idx + CNT_W'(1);
                end
            end
            ST_FCS: begin
                d.out_en   = 1'b1;
                d.out_data = 8'(fcs_word >> {q.idx[1:0], 3'b000});
                if (q.idx == FCS_LAST_C) begin
                    d.state = ST_GAP;
                    d.idx   = '0;
                end else begin
                    d.idx = q.idx + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (q.idx == IFG_LAST_C) begin
                    d.state = ST_RECV;
                    d.idx   = '0;
                end else begin
                    d.idx = q.idx + CNT_W'(1);
                end
            end
            default: d.state = ST_RECV;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_en     = q.out_en;
    assign out_data   = q.out_data;
    assign drop_count = q.drop;

    // Idle-run tracker used only by the gap check below.
    logic [CNT_W-1:0] idle_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run_q <= IFG_C;
        end else if (q.out_en) begin
            idle_run_q <= '0;
        end else if (idle_run_q < IFG_C) begin
            idle_run_q <= idle_run_q + CNT_W'(1);
        end
    end

    assert_input_held_R8: assert property (@(posedge clk) disable iff (rst)
        q.out_en |-> !in_ready);

    assert_preamble_first_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(q.out_en) |-> (q.out_data == 8'h55));

    assert_gap_kept_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q.out_en) |-> (idle_run_q >= IFG_C));

    assert_drop_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.drop) |-> (q.drop == $past(q.drop) + DROP_W'(1)));

endmodule

// File: tb/runt_pad_framer_tb.sv
module runt_pad_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // Stimulus: payload length; expected result: content bytes after padding.
    localparam int VEC_PAY[NVEC]  = '{0, 1, 45, 46, 47, 200};
    localparam int VEC_DLEN[NVEC] = '{60, 60, 60, 60, 61, 214};
    localparam int VEC_SEED[NVEC] = '{3, 17, 91, 5, 200, 64};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_en;
    logic [7:0]  out_data;
    logic [15:0] drop_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    runt_pad_framer u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .out_en     (out_en),
        .out_data   (out_data),
        .drop_count (drop_count)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] cap[$];
    logic [7:0] exp_q[$];
    int idle_run = 100000;
    int min_gap  = 100000;
    int overlap  = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_en) begin
                cap.push_back(out_data);
                if (idle_run > 0 && idle_run < min_gap) min_gap = idle_run;
                idle_run = 0;
                if (in_ready) overlap++;
            end else if (idle_run < 100000) begin
                idle_run++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int i);
        return 8'(seed + i * 13);
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[k];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic build_exp(input int total, input int seed);
        int dlen;
        int plen;
        logic [31:0] crc;
        dlen = total - 4;
        plen = (dlen < 60) ? 60 : dlen;
        for (int i = 0; i < 7; i++) exp_q.push_back(8'h55);
        exp_q.push_back(8'hD5);
        crc = 32'hFFFFFFFF;
        for (int i = 0; i < plen; i++) begin
            logic [7:0] b;
            b = (i < dlen) ? gen(seed, i) : 8'h00;
            exp_q.push_back(b);
            crc = crc_upd(crc, b);
        end
        crc = ~crc;
        for (int i = 0; i < 4; i++) exp_q.push_back(crc[8*i +: 8]);
    endtask

    task automatic send(input int total, input int seed);
        logic [31:0] junk;
        junk = 32'hDEADBEEF;
        @(negedge clk);
        for (int i = 0; i < total; i++) begin
            in_valid = 1'b1;
            in_data  = (i < total - 4) ? gen(seed, i) : junk[8*(i - total + 4) +: 8];
            in_last  = (i == total - 1);
            forever begin
                bit ok;
                ok = in_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input string dreq);
        int bad;
        int first;
        int n;
        n = exp_q.size();
        check(cap.size() == n, dreq, "output length", cap.size(), n);
        if (cap.size() == n && n >= 12) begin
            bad = 0; first = 0;
            for (int i = 0; i < 8; i++) if (cap[i] !== exp_q[i]) begin if (bad == 0) first = i; bad++; end
            check(bad == 0, "R2", "preamble byte", bad ? int'(cap[first]) : 0, bad ? int'(exp_q[first]) : 0);
            bad = 0; first = 0;
            for (int i = 8; i < n - 4; i++) if (cap[i] !== exp_q[i]) begin if (bad == 0) first = i; bad++; end
            check(bad == 0, dreq, "content byte", bad ? int'(cap[first]) : 0, bad ? int'(exp_q[first]) : 0);
            bad = 0; first = 0;
            for (int i = n - 4; i < n; i++) if (cap[i] !== exp_q[i]) begin if (bad == 0) first = i; bad++; end
            check(bad == 0, "R5", "FCS byte", bad ? int'(cap[first]) : 0, bad ? int'(exp_q[first]) : 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(out_en == 1'b0, "R1", "out_en after reset", out_en, 0);
        check(drop_count == 16'd0, "R1", "drop_count after reset", drop_count, 0);

        // Table walk: R3 for runts, R4 for legal lengths
        for (int v = 0; v < NVEC; v++) begin
            int total;
            total = 14 + VEC_PAY[v] + 4;
            cap.delete();
            exp_q.delete();
            build_exp(total, VEC_SEED[v]);
            send(total, VEC_SEED[v]);
            wait_done();
            check_frame((total < 64) ? "R3" : "R4");
            check(cap.size() - 12 == VEC_DLEN[v], (total < 64) ? "R3" : "R4",
                  "content length", cap.size() - 12, VEC_DLEN[v]);
        end
        check(overlap == 0, "R8", "cycles with out_en and in_ready both high", overlap, 0);

        // R7: oversized frame is dropped
        cap.delete();
        send(1519, 7);
        repeat (20) @(negedge clk);
        check(cap.size() == 0, "R7", "bytes emitted for oversized frame", cap.size(), 0);
        check(drop_count == 16'd1, "R7", "drop_count after oversize", drop_count, 1);

        // R9: maximum-size frame forwarded
        cap.delete();
        exp_q.delete();
        build_exp(1518, 29);
        send(1518, 29);
        wait_done();
        check_frame("R9");

        // R6: back-to-back frames keep the gap
        cap.delete();
        exp_q.delete();
        min_gap = 100000;
        build_exp(18, 101);
        build_exp(70, 55);
        send(18, 101);
        send(70, 55);
        wait_done();
        check(cap.size() == exp_q.size(), "R6", "two-frame length", cap.size(), exp_q.size());
        begin
            int bad;
            bad = 0;
            if (cap.size() == exp_q.size())
                for (int i = 0; i < cap.size(); i++) if (cap[i] !== exp_q[i]) bad++;
            check(bad == 0, "R6", "two-frame mismatched bytes", bad, 0);
        end
        check(min_gap >= 12 && min_gap < 100000, "R6", "shortest idle run", min_gap, 12);

        // R7: second drop, then a normal runt still works
        cap.delete();
        exp_q.delete();
        send(1600, 9);
        repeat (5) @(negedge clk);
        check(drop_count == 16'd2, "R7", "drop_count after second oversize", drop_count, 2);
        build_exp(18, 77);
        send(18, 77);
        wait_done();
        check_frame("R7");
        check(overlap == 0, "R8", "cycles with out_en and in_ready both high", overlap, 0);

        summary();
        $finish;
    end
endmodule